// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block regulates the current in one winding of a bipolar motor. It drives the four gates of a single full-bridge, one high-side and one low-side gate on each of the two legs, through a repeating cycle. In the drive phase the bridge pushes current in the requested direction until the synchronised sense comparator reports that the current has reached its trip level. The bridge then coasts for a fixed number of clock cycles, called the off-time, and drives again.

Each off-time is either slow decay, where both low-side gates recirculate the current, or mixed decay. A mixed off-time begins with a fast-decay portion (5/16 of the off-time) in which the opposite diagonal is switched on, and then continues in slow decay. Comparator edges caused by switching are masked by a blanking counter. Complementary gates in a leg are separated by a dead time. Decay transistors conduct synchronously but are released once the winding current reaches zero. All durations are clock-cycle counts taken from parameters or from a run-time off-time input.

Top module: `offtime_chopper`

## Requirements
- R1: After reset, and at every moment while `en` is low, all four gate outputs are low.
- R2: The polarity input is sampled once, when a drive phase begins. With a sample of 0 the drive phase turns on `a_hi` and `b_lo`; with a sample of 1 it turns on `b_hi` and `a_lo`. A change of the polarity input during a drive phase does not alter the gates.
- R3: The trip input is ignored while the blanking counter runs. The counter restarts at every gate change and masks the next BLANK_CYC clock edges. If trip is held high, the drive gates stay on for exactly BLANK_CYC+2 cycles.
- R4: An accepted trip starts an off-time of N cycles, measured from the fall of the drive high-side gate to the fall of the low-side gate in the same leg. N is `off_cycles`, or OFF_DEF_CYC when `off_cycles` is 0.
- R5: When `mixed_req` is high at the trip, the first floor(5·N/16) cycles of the off-time are fast decay on the opposite diagonal (for polarity 0: `b_hi` and `a_lo`). The fast high-side gate falls exactly floor(5·N/16) cycles after the drive high-side gate falls. Both high-side gates are never on together.
- R6: When `mixed_req` is low at the trip, the whole off-time is slow decay: both low-side gates are on and neither high-side gate turns on.
- R7: At the end of the off-time the drive phase starts again. With trip held high the chop repeats with a period of BLANK_CYC+2+N+DEAD_CYC cycles.
- R8: A zero-current flag seen during an off-time turns all four gates off by the second clock edge. The gates stay off for the rest of that off-time, and the drive high-side gate returns exactly N cycles after it fell.
- R9: In each leg the high-side and low-side gates are never on together. Between one turning off and the other turning on, both stay low for exactly DEAD_CYC cycles.
- R10: Lowering `en` forces all gates low in the same cycle and returns the controller to idle. Raising it again starts a new drive phase with a freshly sampled polarity, and the first cycle after re-enable has all gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Supervisor enable; low forces the bridge off |
| trip | input | 1 | Synchronised sense-comparator trip |
| mixed_req | input | 1 | Decay request: 1 mixed, 0 slow |
| polarity | input | 1 | Target current direction |
| zero_i | input | 1 | Winding current has reached zero |
| off_cycles | input | OFF_W | Off-time in cycles; 0 selects OFF_DEF_CYC |
| a_hi | output | 1 | Leg A high-side gate |
| a_lo | output | 1 | Leg A low-side gate |
| b_hi | output | 1 | Leg B high-side gate |
| b_lo | output | 1 | Leg B low-side gate |

## Verification
The bench builds the controller with BLANK_CYC=8, DEAD_CYC=3, OFF_DEF_CYC=64 and an 8-bit off-time input. These values keep a whole chop period under a hundred cycles, so repeated periods, the default off-time and the zero-current release can all be measured edge to edge. Off-times of 32 and 48 give fast portions of 10 and 15 cycles. Both are longer than the dead time, so the opposite-diagonal pattern actually appears and its end can be timed.

// File: rtl/offtime_chopper.sv
module offtime_chopper #(
  parameter int BLANK_CYC   = 100,
  parameter int DEAD_CYC    = 48,
  parameter int OFF_DEF_CYC = 3000,
  parameter int OFF_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trip,
  input  logic             mixed_req,
  input  logic             polarity,
  input  logic             zero_i,
  input  logic [OFF_W-1:0] off_cycles,
  output logic             a_hi,
  output logic             a_lo,
  output logic             b_hi,
  output logic             b_lo
);

  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_FAST, S_SLOW} st_t;

  st_t              st;
  logic             pol_q, zero_q;
  logic [OFF_W-1:0] off_q, fast_q, off_cnt, cnt_nx;
  logic [OFF_W-1:0] off_len, fast_len;
  logic [OFF_W+2:0] off5;
  logic [BW-1:0]    blank;
  logic [1:0][1:0]  tgt, outv;
  logic [1:0]       chg;
  logic             accept;

  assign off_len  = (off_cycles == '0) ? OFF_W'(OFF_DEF_CYC) : off_cycles;
  assign off5     = {3'b000, off_len} + {1'b0, off_len, 2'b00};
  assign fast_len = OFF_W'(off5 >> 4);
  assign cnt_nx   = off_cnt + 1'b1;

  always_comb begin
    tgt = '0;
    case (st)
      S_DRIVE: begin
        tgt[0] = pol_q ? 2'b01 : 2'b10;
        tgt[1] = pol_q ? 2'b10 : 2'b01;
      end
      S_FAST: if (!zero_q) begin
        tgt[0] = pol_q ? 2'b10 : 2'b01;
        tgt[1] = pol_q ? 2'b01 : 2'b10;
      end
      S_SLOW: if (!zero_q) begin
        tgt[0] = 2'b01;
        tgt[1] = 2'b01;
      end
      default: tgt = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_leg
    logic [1:0]    q, nxt;
    logic [DW-1:0] dc, dnx;

    always_comb begin
      nxt = q;
      dnx = dc;
      if (!en) begin
        nxt = '0;
        dnx = DW'(DEAD_CYC - 1);
      end else if (q != tgt[g] && q != 2'b00) begin
        nxt = '0;
        dnx = DW'(DEAD_CYC - 1);
      end else if (dc != '0) begin
        dnx = dc - 1'b1;
      end else begin
        nxt = tgt[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        q  <= '0;
        dc <= '0;
      end else begin
        q  <= nxt;
        dc <= dnx;
      end

    assign chg[g]  = (nxt != q);
    assign outv[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               blank <= '0;
    else if (|chg)            blank <= BW'(BLANK_CYC);
    else if (blank != '0)     blank <= blank - 1'b1;

  assign accept = (st == S_DRIVE) && trip && (blank == '0) && (outv == tgt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      pol_q   <= 1'b0;
      zero_q  <= 1'b0;
      off_q   <= '0;
      fast_q  <= '0;
      off_cnt <= '0;
    end else if (!en) begin
      st     <= S_IDLE;
      zero_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          st    <= S_DRIVE;
          pol_q <= polarity;
        end
        S_DRIVE: begin
          zero_q <= 1'b0;
          if (accept) begin
            off_q   <= off_len;
            fast_q  <= fast_len;
            off_cnt <= '0;
            st      <= (mixed_req && fast_len != '0) ? S_FAST : S_SLOW;
          end
        end
        default: begin
          if (zero_i) zero_q <= 1'b1;
          off_cnt <= cnt_nx;
          if (cnt_nx == off_q) begin
            st     <= S_DRIVE;
            pol_q  <= polarity;
            zero_q <= 1'b0;
          end else if (st == S_FAST && cnt_nx == fast_q) begin
            st <= S_SLOW;
          end
        end
      endcase
    end

  assign a_hi = en & outv[0][1];
  assign a_lo = en & outv[0][0];
  assign b_hi = en & outv[1][1];
  assign b_lo = en & outv[1][0];

endmodule

// File: rtl/chopper_checks.sv
module chopper_checks (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic a_hi,
  input logic a_lo,
  input logic b_hi,
  input logic b_lo
);

  assert_leg_a_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi && a_lo));

  assert_leg_b_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_hi && b_lo));

  assert_dead_a_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_lo) |-> !$past(a_hi));

  assert_dead_a_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_hi) |-> !$past(a_lo));

  assert_dead_b_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_lo) |-> !$past(b_hi));

  assert_dead_b_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_hi) |-> !$past(b_lo));

  assert_high_sides_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi && b_hi));

  assert_reenable_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !(a_hi || a_lo || b_hi || b_lo));

  assert_drive_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_hi) |=> (a_hi || !en));

endmodule

bind offtime_chopper chopper_checks u_chopper_checks (
  .clk  (clk),
  .rst_n(rst_n),
  .en   (en),
  .a_hi (a_hi),
  .a_lo (a_lo),
  .b_hi (b_hi),
  .b_lo (b_lo)
);

// File: tb/test_offtime_chopper.sv
module test_offtime_chopper;

  localparam int BLANK = 8;
  localparam int DEAD  = 3;
  localparam int ODEF  = 64;
  localparam int OW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, trip = 1'b0, mixed_req = 1'b0, polarity = 1'b0, zero_i = 1'b0;
  logic [OW-1:0] off_cycles = '0;
  logic a_hi, a_lo, b_hi, b_lo;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  logic bhi_seen = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (b_hi) bhi_seen = 1'b1;

  offtime_chopper #(.BLANK_CYC(BLANK), .DEAD_CYC(DEAD), .OFF_DEF_CYC(ODEF), .OFF_W(OW))
    i_offtime_chopper (
      .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .mixed_req(mixed_req),
      .polarity(polarity), .zero_i(zero_i), .off_cycles(off_cycles),
      .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo));

  function automatic logic gate(int i);
    case (i)
      0: return a_hi;
      1: return a_lo;
      2: return b_hi;
      default: return b_lo;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_gates(string req, logic [3:0] exp);
    chk(req, {a_hi, a_lo, b_hi, b_lo}, exp);
  endtask

  task automatic wait_for(string req, int idx, logic v, output int t);
    int n = 0;
    while (gate(idx) !== v && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (gate(idx) !== v) begin
      nchk++;
      nerr++;
      $display("FAIL %s: gate %0d actual %0d expected %0d (timeout)", req, idx, gate(idx), v);
    end
    t = cyc;
  endtask

  task automatic idle_bench();
    @(negedge clk);
    en = 1'b0; trip = 1'b0; zero_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_gates("R1 reset", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    trip = 1'b1; polarity = 1'b1;
    repeat (5) @(negedge clk);
    chk_gates("R1 disabled", 4'b0000);
    idle_bench();
  endtask

  task automatic t_polarity_enable();
    polarity = 1'b1; trip = 1'b0; en = 1'b1;
    repeat (15) @(negedge clk);
    chk_gates("R2 pol1 drive", 4'b0110);
    polarity = 1'b0;
    repeat (10) @(negedge clk);
    chk_gates("R2 pol held", 4'b0110);
    en = 1'b0;
    #1;
    chk_gates("R10 drop", 4'b0000);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (15) @(negedge clk);
    chk_gates("R10 re-enable pol0", 4'b1001);
    idle_bench();
  endtask

  task automatic t_blank_ignore();
    int t;
    polarity = 1'b0; trip = 1'b0; en = 1'b1;
    wait_for("R3", 0, 1'b1, t);
    @(negedge clk);
    trip = 1'b1;
    repeat (3) @(negedge clk);
    trip = 1'b0;
    repeat (20) @(negedge clk);
    chk_gates("R3 trip in blank ignored", 4'b1001);
    idle_bench();
  endtask

  task automatic t_chop(logic mix, int offc, int n);
    int tr, tf, ta, tb, tl, tr2, tf2;
    int fast = (n * 5) / 16;
    polarity = 1'b0; mixed_req = mix; off_cycles = OW'(offc); trip = 1'b1; en = 1'b1;
    wait_for("R3", 0, 1'b1, tr);
    wait_for("R3", 0, 1'b0, tf);
    chk("R3 on-time", tf - tr, BLANK + 2);
    bhi_seen = 1'b0;
    wait_for("R9", 1, 1'b1, ta);
    chk("R9 dead gap", ta - tf, DEAD);
    if (mix) begin
      chk("R5 fast diagonal", b_hi, 1);
      wait_for("R5", 2, 1'b0, tb);
      chk("R5 fast length", tb - tf, fast);
    end else begin
      chk("R6 low sides on", b_lo, 1);
    end
    wait_for("R4", 1, 1'b0, tl);
    chk("R4 off-time", tl - tf, n);
    if (!mix) chk("R6 no high side", bhi_seen, 0);
    wait_for("R7", 0, 1'b1, tr2);
    chk("R7 period", tr2 - tr, BLANK + 2 + n + DEAD);
    wait_for("R7", 0, 1'b0, tf2);
    chk("R7 repeat on-time", tf2 - tr2, BLANK + 2);
    idle_bench();
  endtask

  task automatic t_zero();
    int t0, t1;
    polarity = 1'b0; mixed_req = 1'b0; off_cycles = OW'(32); trip = 1'b1; en = 1'b1;
    wait_for("R8", 0, 1'b1, t0);
    wait_for("R8", 0, 1'b0, t0);
    trip = 1'b0;
    repeat (10) @(negedge clk);
    zero_i = 1'b1;
    repeat (2) @(negedge clk);
    chk_gates("R8 all off", 4'b0000);
    zero_i = 1'b0;
    repeat (5) @(negedge clk);
    chk_gates("R8 stays off", 4'b0000);
    wait_for("R8", 0, 1'b1, t1);
    chk("R8 drive return", t1 - t0, 32);
    idle_bench();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_polarity_enable();
    t_blank_ignore();
    t_chop(1'b1, 32, 32);
    t_chop(1'b1, 48, 48);
    t_chop(1'b0, 32, 32);
    t_chop(1'b0, 0, ODEF);
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule